// File: doc/BRIEF.md
# Oversampling Serial Receiver with Status Queue

This block is the receive half of an asynchronous serial port. It synchronizes the incoming line, watches for a high-to-low transition while idle, and then walks through the start bit, the data bits, an optional parity bit and one or two stop bits. It counts an oversample enable (`os_tick`) that an external rate generator supplies. Each bit lasts 16 oversamples, or 8 when the fast mode is selected. The frame settings are captured when the start edge is seen, so they cannot change partway through a character.

The start and stop bits are held to a stricter rule than the data bits. Every oversample of the start bit must read low, or the frame is dropped. Every oversample of the stop bits must read high, or the character is marked with a framing error. Data and parity bits are decided by a vote of three oversamples around the bit centre. Each finished character is pushed into a small queue together with four status flags. The queue is read in first-word-fall-through fashion.

Top module: `uart_os_rx`

## Requirements
- R1: While reset is held and just after it is released, `empty` is 1, `full` is 0 and `busy` is 0.
- R2: From idle, a falling edge on the synchronized line starts a frame and raises `busy` before the next oversample tick. A bit lasts 16 ticks when `os8_sel` is 0 and 8 ticks when it is 1. A well-formed frame is stored with status 0.
- R3: If any start-bit oversample reads 1, the frame is abandoned. `busy` returns to 0 and no entry is written.
- R4: Data bits are taken LSB first. Each bit is the majority of the oversamples at positions N/2-1, N/2 and N/2+1 of that bit (counted from 0, where N is 8 or 16), so a single wrong oversample at the centre does not change the bit.
- R5: There is one stop bit, or two when `two_stop` is 1. If any stop oversample reads 0, status bit 0 (framing error) is set for that character, and the data is still stored.
- R6: When `par_en` is 1, a parity bit follows the data. The expected parity is even when `par_odd` is 0 and odd when it is 1. A mismatch sets status bit 1.
- R7: If all data bits, the parity bit (when present) and every stop oversample read 0, status bit 2 (break) is set together with status bit 0.
- R8: Each queue entry holds the data on `rd_data` and the status on `rd_stat`, head first. `rd_en` removes the head when the queue is not empty. `full` rises after DEPTH unread entries (default 4).
- R9: A character that completes while the queue is full is discarded, and status bit 3 (overrun) is set on the next entry that is written.
- R10: `busy` stays 1 through the last stop oversample and falls on the tick that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-cycle oversample enable from the rate generator |
| os8_sel | input | 1 | 1 selects 8 oversamples per bit, 0 selects 16 |
| par_en | input | 1 | Expect a parity bit after the data |
| par_odd | input | 1 | 1 for odd parity, 0 for even |
| two_stop | input | 1 | Expect two stop bits |
| rxd | input | 1 | Asynchronous serial line, idle high |
| rd_en | input | 1 | Remove the head entry |
| rd_data | output | DATA_W | Data of the head entry |
| rd_stat | output | 4 | Status of the head entry: bit0 framing, bit1 parity, bit2 break, bit3 overrun |
| empty | output | 1 | Queue holds no entry |
| full | output | 1 | Queue holds DEPTH entries |
| busy | output | 1 | A frame is being received |

## Verification
Most faults in the bit counter or the phase register show up on the ports as a wrong `busy` edge. If the final stop tick is off by one, `busy` falls one oversample early or late. If a rejected start leaves the machine active, `busy` stays high after the line has returned high. An error in the centre or vote positions shows up when the head entry is read: a glitched centre oversample flips a data bit that should have survived. Status faults appear on `rd_stat` of the very character that caused them. The one exception is overrun, which can only appear on the entry written after the dropped character, so a lost pending flag is seen only when the queue is drained.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_START,
      PH_DATA,
      PH_PAR,
      PH_STOP
   } phase_e;

   typedef struct packed {
      logic os8;
      logic par_en;
      logic par_odd;
      logic two_stop;
   } cfg_t;

   // bit 3 overrun, bit 2 break, bit 1 parity, bit 0 framing
   typedef struct packed {
      logic ovr;
      logic brk;
      logic perr;
      logic ferr;
   } stat_t;

   localparam int STAT_W = 4;

endpackage

// File: rtl/uart_os_rx_sync.sv
module uart_os_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout,
   output logic dout_q
);
   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh     <= '1;
         dout_q <= 1'b1;
      end else begin
         sh     <= {sh[STAGES-2:0], din};
         dout_q <= sh[STAGES-1];
      end
   end

   assign dout = sh[STAGES-1];
endmodule

// File: rtl/uart_os_rx_fifo.sv
module uart_os_rx_fifo #(
   parameter int W     = 12,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         rd_en,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wp, rp;
   logic         do_rd;

   assign empty = (wp == rp);
   assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign do_rd = rd_en && !empty;
   assign rdata = mem[rp[AW-1:0]];

   always_ff @(posedge clk) begin
      if (wr) mem[wp[AW-1:0]] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (wr)    wp <= wp + 1'b1;
         if (do_rd) rp <= rp + 1'b1;
      end
   end
endmodule

// File: rtl/uart_os_rx_fsm.sv
module uart_os_rx_fsm
   import uart_os_rx_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter bit MAJORITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              rx_s,
   input  logic              rx_q,
   input  cfg_t              cfg_in,
   output logic              busy,
   output logic              in_start,
   output logic              wr_req,
   output logic [DATA_W-1:0] wr_data,
   output stat_t             wr_stat
);
   localparam int BIT_W = $clog2(DATA_W);

   phase_e            ph;
   cfg_t              cfg;
   logic [3:0]        cnt;
   logic [3:0]        last, mid;
   logic [BIT_W-1:0]  bidx;
   logic [DATA_W-1:0] shr;
   logic [2:0]        votes;
   logic              pbit, ferr, any1, stop2;
   logic              fall, bit_end, bit_val;
   logic              ferr_n, any1_n, perr_n, brk_n;

   assign fall     = rx_q && !rx_s;
   assign last     = cfg.os8 ? 4'd7 : 4'd15;
   assign mid      = cfg.os8 ? 4'd4 : 4'd8;
   assign bit_end  = (cnt == last);
   assign busy     = (ph != PH_IDLE);
   assign in_start = (ph == PH_START);

   generate
      if (MAJORITY) begin : g_vote3
         assign bit_val = (votes[0] & votes[1]) | (votes[0] & votes[2]) |
                          (votes[1] & votes[2]);
      end else begin : g_vote1
         assign bit_val = votes[1];
      end
   endgenerate

   assign ferr_n = ferr | ~rx_s;
   assign any1_n = any1 | rx_s;
   assign perr_n = cfg.par_en && ((^shr ^ pbit) != cfg.par_odd);
   assign brk_n  = (shr == '0) && (!cfg.par_en || !pbit) && !any1_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph      <= PH_IDLE;
         cfg     <= '0;
         cnt     <= '0;
         bidx    <= '0;
         shr     <= '0;
         votes   <= '0;
         pbit    <= 1'b0;
         ferr    <= 1'b0;
         any1    <= 1'b0;
         stop2   <= 1'b0;
         wr_req  <= 1'b0;
         wr_data <= '0;
         wr_stat <= '0;
      end else begin
         wr_req <= 1'b0;
         case (ph)
            PH_IDLE: begin
               if (fall) begin
                  ph  <= PH_START;
                  cnt <= '0;
                  cfg <= cfg_in;
               end
            end
            PH_START: begin
               if (os_tick) begin
                  if (rx_s) begin
                     ph <= PH_IDLE;
                  end else if (bit_end) begin
                     ph   <= PH_DATA;
                     cnt  <= '0;
                     bidx <= '0;
                  end else begin
                     cnt <= cnt + 4'd1;
                  end
               end
            end
            PH_DATA, PH_PAR: begin
               if (os_tick) begin
                  if (cnt == mid - 4'd1) votes[0] <= rx_s;
                  if (cnt == mid)        votes[1] <= rx_s;
                  if (cnt == mid + 4'd1) votes[2] <= rx_s;
                  if (bit_end) begin
                     cnt <= '0;
                     if (ph == PH_PAR) begin
                        pbit  <= bit_val;
                        ph    <= PH_STOP;
                     end else begin
                        shr <= {bit_val, shr[DATA_W-1:1]};
                        if (bidx == BIT_W'(DATA_W - 1)) begin
                           ph    <= cfg.par_en ? PH_PAR : PH_STOP;
                           ferr  <= 1'b0;
                           any1  <= 1'b0;
                           stop2 <= 1'b0;
                        end else begin
                           bidx <= bidx + 1'b1;
                        end
                     end
                  end else begin
                     cnt <= cnt + 4'd1;
                  end
               end
            end
            PH_STOP: begin
               if (os_tick) begin
                  ferr <= ferr_n;
                  any1 <= any1_n;
                  if (bit_end) begin
                     cnt <= '0;
                     if (cfg.two_stop && !stop2) begin
                        stop2 <= 1'b1;
                     end else begin
                        ph           <= PH_IDLE;
                        wr_req       <= 1'b1;
                        wr_data      <= shr;
                        wr_stat.ovr  <= 1'b0;
                        wr_stat.brk  <= brk_n;
                        wr_stat.perr <= perr_n;
                        wr_stat.ferr <= ferr_n;
                     end
                  end else begin
                     cnt <= cnt + 4'd1;
                  end
               end
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
   import uart_os_rx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DEPTH       = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit MAJORITY    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              os8_sel,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              two_stop,
   input  logic              rxd,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic [3:0]        rd_stat,
   output logic              empty,
   output logic              full,
   output logic              busy
);
   localparam int ENTRY_W = DATA_W + STAT_W;

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two of at least 2");
      assert (SYNC_STAGES >= 2)
         else $error("SYNC_STAGES must be at least 2");
      assert (DATA_W >= 5 && DATA_W <= 9)
         else $error("DATA_W must lie in 5..9");
   end

   logic              rx_s, rx_q;
   logic              in_start;
   logic              wr_req, wr_ok;
   logic              ovr_pend;
   logic [DATA_W-1:0] wr_data;
   stat_t             wr_stat, entry_stat;
   cfg_t              cfg_in;
   logic [ENTRY_W-1:0] fifo_out;

   assign cfg_in.os8      = os8_sel;
   assign cfg_in.par_en   = par_en;
   assign cfg_in.par_odd  = par_odd;
   assign cfg_in.two_stop = two_stop;

   uart_os_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (rxd),
      .dout   (rx_s),
      .dout_q (rx_q)
   );

   uart_os_rx_fsm #(.DATA_W(DATA_W), .MAJORITY(MAJORITY)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .os_tick  (os_tick),
      .rx_s     (rx_s),
      .rx_q     (rx_q),
      .cfg_in   (cfg_in),
      .busy     (busy),
      .in_start (in_start),
      .wr_req   (wr_req),
      .wr_data  (wr_data),
      .wr_stat  (wr_stat)
   );

   assign wr_ok = wr_req && !full;

   always_comb begin
      entry_stat     = wr_stat;
      entry_stat.ovr = ovr_pend;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ovr_pend <= 1'b0;
      else if (wr_req) ovr_pend <= full;
   end

   uart_os_rx_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_ok),
      .wdata ({entry_stat, wr_data}),
      .rd_en (rd_en),
      .rdata (fifo_out),
      .empty (empty),
      .full  (full)
   );

   assign rd_data = fifo_out[DATA_W-1:0];
   assign rd_stat = fifo_out[ENTRY_W-1:DATA_W];
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk (
   input logic clk,
   input logic rst_n,
   input logic os_tick,
   input logic busy,
   input logic empty,
   input logic full,
   input logic rd_en,
   input logic rx_s,
   input logic rx_q,
   input logic wr_req,
   input logic in_start
);
   // R8: the two queue flags never coexist
   a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));

   // R2: a frame begins only on a synchronized falling edge
   a_r2_busy_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(rx_q && !rx_s));

   // R3: a high start oversample ends the frame at once
   a_r3_start_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (in_start && os_tick && rx_s) |=> !busy);

   // R8: the queue leaves empty only after a character push
   a_r8_empty_needs_push: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(empty) |-> $past(wr_req));

   // R9: a full queue stays full until read
   a_r9_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !rd_en) |=> full);

   // R10: a character is pushed only once the stop time is over
   a_r10_push_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> !busy);
endmodule

bind uart_os_rx uart_os_rx_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .os_tick  (os_tick),
   .busy     (busy),
   .empty    (empty),
   .full     (full),
   .rd_en    (rd_en),
   .rx_s     (rx_s),
   .rx_q     (rx_q),
   .wr_req   (wr_req),
   .in_start (in_start)
);

// File: tb/uart_os_rx_test.sv
module uart_os_rx_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b0;
   logic       os8_sel = 1'b0;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic       two_stop = 1'b0;
   logic       rxd = 1'b1;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic [3:0] rd_stat;
   logic       empty, full, busy;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   uart_os_rx uut (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .os8_sel(os8_sel),
      .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop), .rxd(rxd),
      .rd_en(rd_en), .rd_data(rd_data), .rd_stat(rd_stat),
      .empty(empty), .full(full), .busy(busy)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one oversample period: value v seen by the receiver on the following tick
   task automatic tk(input logic v);
      rxd     = v;
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic send_bit(input logic v, input int glitch);
      int n = os8_sel ? 8 : 16;
      for (int k = 0; k < n; k++) tk((k == glitch) ? ~v : v);
   endtask

   task automatic frame(input logic [7:0] d, input int dglitch, input logic flip_par,
                        input logic stop_v, input int stop_glitch);
      int n = os8_sel ? 8 : 16;
      tk(1'b0);
      chk("R2 busy after start edge", busy, 1);
      for (int k = 1; k < n; k++) tk(1'b0);
      for (int i = 0; i < 8; i++) send_bit(d[i], (i == 0) ? dglitch : -1);
      if (par_en) send_bit((^d) ^ par_odd ^ flip_par, -1);
      if (two_stop) send_bit(stop_v, -1);
      send_bit(stop_v, stop_glitch);
      chk("R10 busy through last stop oversample", busy, 1);
      tk(1'b1);
      chk("R10 busy falls after stop", busy, 0);
      tk(1'b1);
      repeat (4) @(negedge clk);
   endtask

   task automatic pop(input string req, input logic [7:0] ed, input logic [3:0] es);
      chk({req, " not empty"}, empty, 0);
      chk({req, " data"}, rd_data, ed);
      chk({req, " status"}, rd_stat, es);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 empty in reset", empty, 1);
      chk("R1 full in reset", full, 0);
      chk("R1 busy in reset", busy, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 empty after reset", empty, 1);
      chk("R1 busy after reset", busy, 0);
   endtask

   task automatic t_basic();
      os8_sel = 1'b0;
      frame(8'hA5, -1, 1'b0, 1'b1, -1);
      pop("R2 16x frame", 8'hA5, 4'h0);
      os8_sel = 1'b1;
      frame(8'h3C, -1, 1'b0, 1'b1, -1);
      pop("R2 8x frame", 8'h3C, 4'h0);
      os8_sel = 1'b0;
      chk("R8 empty after pops", empty, 1);
   endtask

   task automatic t_vote();
      frame(8'h81, 8, 1'b0, 1'b1, -1);
      pop("R4 centre glitch 16x", 8'h81, 4'h0);
      os8_sel = 1'b1;
      frame(8'h4E, 4, 1'b0, 1'b1, -1);
      pop("R4 centre glitch 8x", 8'h4E, 4'h0);
      os8_sel = 1'b0;
   endtask

   task automatic t_start_reject();
      tk(1'b0);
      tk(1'b0);
      tk(1'b0);
      for (int k = 0; k < 5; k++) tk(1'b1);
      chk("R3 busy low after rejected start", busy, 0);
      for (int k = 0; k < 150; k++) tk(1'b1);
      chk("R3 no entry from rejected start", empty, 1);
      chk("R3 still idle", busy, 0);
   endtask

   task automatic t_stop();
      frame(8'h5A, -1, 1'b0, 1'b1, 3);
      pop("R5 stop glitch framing", 8'h5A, 4'h1);
      two_stop = 1'b1;
      frame(8'hC3, -1, 1'b0, 1'b1, -1);
      pop("R5 two stops clean", 8'hC3, 4'h0);
      frame(8'h96, -1, 1'b0, 1'b1, 15);
      pop("R5 second stop glitch", 8'h96, 4'h1);
      two_stop = 1'b0;
   endtask

   task automatic t_parity();
      par_en = 1'b1;
      par_odd = 1'b0;
      frame(8'h07, -1, 1'b0, 1'b1, -1);
      pop("R6 even parity ok", 8'h07, 4'h0);
      frame(8'h07, -1, 1'b1, 1'b1, -1);
      pop("R6 even parity error", 8'h07, 4'h2);
      par_odd = 1'b1;
      frame(8'h33, -1, 1'b0, 1'b1, -1);
      pop("R6 odd parity ok", 8'h33, 4'h0);
      par_en = 1'b0;
      par_odd = 1'b0;
   endtask

   task automatic t_break();
      frame(8'h00, -1, 1'b0, 1'b0, -1);
      pop("R7 break", 8'h00, 4'h5);
      frame(8'h00, -1, 1'b0, 1'b1, -1);
      pop("R7 zero data is not break", 8'h00, 4'h0);
   endtask

   task automatic t_overrun();
      frame(8'h11, -1, 1'b0, 1'b1, -1);
      frame(8'h22, -1, 1'b0, 1'b1, -1);
      frame(8'h33, -1, 1'b0, 1'b1, -1);
      chk("R8 not full at three", full, 0);
      frame(8'h44, -1, 1'b0, 1'b1, -1);
      chk("R8 full at depth", full, 1);
      frame(8'h55, -1, 1'b0, 1'b1, -1);
      chk("R9 still full after drop", full, 1);
      pop("R9 head kept", 8'h11, 4'h0);
      chk("R8 not full after read", full, 0);
      frame(8'h66, -1, 1'b0, 1'b1, -1);
      pop("R9 second", 8'h22, 4'h0);
      pop("R9 third", 8'h33, 4'h0);
      pop("R9 fourth", 8'h44, 4'h0);
      pop("R9 overrun marked", 8'h66, 4'h8);
      chk("R8 empty after drain", empty, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_basic();
      t_vote();
      t_start_reject();
      t_stop();
      t_parity();
      t_break();
      t_overrun();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule